// File: doc/BRIEF.md
# Fine-edge PWM generator

This block produces an edge-aligned pulse-width-modulated output from a free-running counter. An up-counter advances once per selected number of instruction cycles and restarts from zero after reaching the active period value. The output rises each time the counter restarts. It falls when the counter equals the active duty value. The resolution of that falling edge is improved with a small fine-delay code. The code holds the falling edge back by a whole number of fast system-clock ticks. Four of those ticks make one instruction cycle, so the code adds two bits of duty resolution below one counter step.

Software-side logic programs the unit through a simple write port. One control word holds the mode, the prescaler select and the fine-delay code. Two further words hold the period and the duty. Period, duty and fine delay are staged and only reach the comparator when the counter restarts, so a change never produces a torn period. A single-compare mode is also provided. In that mode the output starts high and drops once on the first duty match.

Top module: `pwmfd_top`

## Requirements
- R1: While the mode field (control bits [2:0]) holds 3'b000, or any code other than 3'b001, 3'b110 and 3'b111, the output is low from the second clock edge after the write, and the counter, tick phase and prescaler are held at zero. The output is low out of reset.
- R2: In a PWM mode (3'b110 or 3'b111), the output rises in the cycle after the counter state returns to zero, and one full period lasts 4*N*(P+1) clock cycles, where P is the active period and N the prescale ratio. The counter never exceeds the active period.
- R3: In a PWM mode with 0 < duty D <= P, the output is high for 4*N*D + F clock cycles per period, where F is the active fine-delay code.
- R4: The fine-delay code (control bits [9:8]) delays only the falling edge, by F clock ticks from the start of the instruction cycle in which the match occurs. Code 2'b10 places the edge half way through that cycle. The rising edge never moves.
- R5: The prescale select (control bits [5:4]) codes 0, 1, 2 and 3 give N = 1, 8, 64 and 256 instruction cycles per counter step. The fine delay is still counted in clock ticks, not in counter steps.
- R6: Writes to the period (address 1), the duty (address 2) and the fine-delay code are staged. They take effect only at the next counter restart, or at once while the unit is disabled. Mode and prescale select (address 0) take effect at the next clock edge.
- R7: A duty of 0 holds the output low for the whole period, and a duty above the period holds it high for the whole period. The fine-delay code has no effect in either case.
- R8: In single-compare mode (3'b001), the output is high from the cycle after the mode is entered until the first match of the counter with the duty. It is then low until the mode is rewritten. High time is 4*N*D cycles, whatever the fine-delay code.
- R9: A write with wr_en high stores wr_data into the word selected by wr_addr (0 control, 1 period, 2 duty). Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock, four ticks per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | Modulated output |

## Verification
A wrong tick phase or prescaler count shows first as a high time that is off by the fine code or by whole instruction cycles. It appears at the first falling edge, within one period. A counter or staged period that is loaded at the wrong moment stretches or shortens the period, so the next rising edge arrives early or late. A missed staging shows in the period during which the write happened, because that period must still carry the old high time. Faults in the single-compare path show as a high interval of the wrong length, or as a second pulse after the first counter restart.

// File: rtl/pwmfd_pkg.sv
package pwmfd_pkg;

   localparam logic [2:0] MODE_OFF     = 3'b000;
   localparam logic [2:0] MODE_ONESHOT = 3'b001;
   localparam logic [2:0] MODE_PWM     = 3'b110;
   localparam logic [2:0] MODE_PWM_ALT = 3'b111;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_PER  = 2'd1;
   localparam logic [1:0] ADDR_DUTY = 2'd2;

   localparam int CTRL_MODE_LSB = 0;
   localparam int CTRL_PSEL_LSB = 4;
   localparam int CTRL_FINE_LSB = 8;

   typedef enum logic [1:0] {
      RUN_IDLE    = 2'd0,
      RUN_ONESHOT = 2'd1,
      RUN_PWM     = 2'd2
   } run_e;

   function automatic run_e decode_mode(input logic [2:0] m);
      run_e r;
      case (m)
         MODE_ONESHOT:           r = RUN_ONESHOT;
         MODE_PWM, MODE_PWM_ALT: r = RUN_PWM;
         default:                r = RUN_IDLE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pwmfd_regs.sv
module pwmfd_regs
   import pwmfd_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int FINE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [TMR_W-1:0]  wr_data,
   output logic [2:0]        mode_o,
   output logic [1:0]        psel_o,
   output logic [FINE_W-1:0] fine_o,
   output logic [TMR_W-1:0]  per_o,
   output logic [TMR_W-1:0]  duty_o
);

   logic [2:0]        mode_q;
   logic [1:0]        psel_q;
   logic [FINE_W-1:0] fine_q;
   logic [TMR_W-1:0]  per_q;
   logic [TMR_W-1:0]  duty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         psel_q <= '0;
         fine_q <= '0;
         per_q  <= '0;
         duty_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: begin
               mode_q <= wr_data[CTRL_MODE_LSB +: 3];
               psel_q <= wr_data[CTRL_PSEL_LSB +: 2];
               fine_q <= wr_data[CTRL_FINE_LSB +: FINE_W];
            end
            ADDR_PER:  per_q  <= wr_data;
            ADDR_DUTY: duty_q <= wr_data;
            default: ;
         endcase
      end
   end

   assign mode_o = mode_q;
   assign psel_o = psel_q;
   assign fine_o = fine_q;
   assign per_o  = per_q;
   assign duty_o = duty_q;

endmodule

// File: rtl/pwmfd_tick.sv
module pwmfd_tick #(
   parameter int TICK_W   = 2,
   parameter bit PRESC_EN = 1'b1,
   parameter int PRE_L1   = 3,
   parameter int PRE_L2   = 6,
   parameter int PRE_L3   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [1:0]        psel,
   output logic [TICK_W-1:0] ph_o,
   output logic              first_cyc_o,
   output logic              adv_o
);

   localparam logic [TICK_W-1:0] PH_LAST = '1;

   logic [TICK_W-1:0] ph_q;
   logic              cyc_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= '0;
      else if (!run) ph_q <= '0;
      else           ph_q <= ph_q + 1'b1;
   end

   assign cyc_end = run && (ph_q == PH_LAST);
   assign ph_o    = ph_q;

   generate
      if (PRESC_EN) begin : g_presc
         localparam int PC_W = PRE_L3;
         logic [PC_W-1:0] pc_q;
         logic [PC_W-1:0] lim;

         always_comb begin
            case (psel)
               2'd0:    lim = '0;
               2'd1:    lim = PC_W'((1 << PRE_L1) - 1);
               2'd2:    lim = PC_W'((1 << PRE_L2) - 1);
               default: lim = PC_W'((1 << PRE_L3) - 1);
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pc_q <= '0;
            else if (!run)    pc_q <= '0;
            else if (cyc_end) pc_q <= (pc_q >= lim) ? '0 : pc_q + 1'b1;
         end

         assign adv_o       = cyc_end && (pc_q >= lim);
         assign first_cyc_o = (pc_q == '0);
      end else begin : g_nopresc
         assign adv_o       = cyc_end;
         assign first_cyc_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pwmfd_timebase.sv
module pwmfd_timebase #(
   parameter int TMR_W  = 16,
   parameter int FINE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   input  logic [TMR_W-1:0]  per_buf,
   input  logic [TMR_W-1:0]  duty_buf,
   input  logic [FINE_W-1:0] fine_buf,
   output logic [TMR_W-1:0]  tmr_o,
   output logic [TMR_W-1:0]  per_act_o,
   output logic [TMR_W-1:0]  duty_act_o,
   output logic [FINE_W-1:0] fine_act_o,
   output logic              wrap_o
);

   logic [TMR_W-1:0]  tmr_q;
   logic [TMR_W-1:0]  per_act;
   logic [TMR_W-1:0]  duty_act;
   logic [FINE_W-1:0] fine_act;
   logic              at_end;

   assign at_end = (tmr_q == per_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         per_act  <= '0;
         duty_act <= '0;
         fine_act <= '0;
      end else if (!run) begin
         tmr_q    <= '0;
         per_act  <= per_buf;
         duty_act <= duty_buf;
         fine_act <= fine_buf;
      end else if (adv) begin
         if (at_end) begin
            tmr_q    <= '0;
            per_act  <= per_buf;
            duty_act <= duty_buf;
            fine_act <= fine_buf;
         end else begin
            tmr_q <= tmr_q + 1'b1;
         end
      end
   end

   assign tmr_o      = tmr_q;
   assign per_act_o  = per_act;
   assign duty_act_o = duty_act;
   assign fine_act_o = fine_act;
   assign wrap_o     = run && adv && at_end;

endmodule

// File: rtl/pwmfd_outgen.sv
module pwmfd_outgen
   import pwmfd_pkg::*;
#(
   parameter int TMR_W      = 16,
   parameter int FINE_W     = 2,
   parameter bit ONESHOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  run_e              run_mode,
   input  logic [TMR_W-1:0]  tmr,
   input  logic [TMR_W-1:0]  duty_act,
   input  logic [FINE_W-1:0] fine_act,
   input  logic [FINE_W-1:0] ph,
   input  logic              first_cyc,
   output logic              pwm_o
);

   logic hit;
   logic tail;
   logic pwm_nxt;
   logic pwm_q;
   logic shot_nxt;

   assign hit  = (tmr == duty_act);
   assign tail = (duty_act != '0) && hit && first_cyc && (ph < fine_act);

   generate
      if (ONESHOT_EN) begin : g_oneshot
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        done_q <= 1'b0;
            else if (run_mode == RUN_ONESHOT)  done_q <= done_q | hit;
            else                               done_q <= 1'b0;
         end
         assign shot_nxt = !(done_q || hit);
      end else begin : g_no_oneshot
         assign shot_nxt = 1'b0;
      end
   endgenerate

   always_comb begin
      case (run_mode)
         RUN_PWM:     pwm_nxt = (tmr < duty_act) || tail;
         RUN_ONESHOT: pwm_nxt = shot_nxt;
         default:     pwm_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= pwm_nxt;
   end

   assign pwm_o = pwm_q;

endmodule

// File: rtl/pwmfd_top.sv
module pwmfd_top
   import pwmfd_pkg::*;
#(
   parameter int TMR_W      = 16,
   parameter int TICK_W     = 2,
   parameter bit PRESC_EN   = 1'b1,
   parameter int PRE_L1     = 3,
   parameter int PRE_L2     = 6,
   parameter int PRE_L3     = 8,
   parameter bit ONESHOT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [TMR_W-1:0] wr_data,
   output logic             pwm_o
);

   localparam int FINE_W = TICK_W;

   generate
      if (TICK_W < 1) begin : g_bad_tick
         $error("pwmfd_top: TICK_W must be at least 1");
      end
      if (TMR_W < CTRL_FINE_LSB + FINE_W) begin : g_bad_width
         $error("pwmfd_top: TMR_W too narrow for the control word");
      end
      if (PRE_L1 < 1 || PRE_L1 >= PRE_L2 || PRE_L2 >= PRE_L3) begin : g_bad_presc
         $error("pwmfd_top: prescale exponents must rise strictly");
      end
   endgenerate

   logic [2:0]        mode_q;
   logic [1:0]        psel;
   logic [FINE_W-1:0] fine_buf;
   logic [TMR_W-1:0]  per_buf;
   logic [TMR_W-1:0]  duty_buf;
   run_e              run_mode;
   logic              run;
   logic [TICK_W-1:0] ph;
   logic              first_cyc;
   logic              adv;
   logic [TMR_W-1:0]  tmr;
   logic [TMR_W-1:0]  per_act;
   logic [TMR_W-1:0]  duty_act;
   logic [FINE_W-1:0] fine_act;
   logic              wrap;

   assign run_mode = decode_mode(mode_q);
   assign run      = (run_mode != RUN_IDLE);

   pwmfd_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mode_o  (mode_q),
      .psel_o  (psel),
      .fine_o  (fine_buf),
      .per_o   (per_buf),
      .duty_o  (duty_buf)
   );

   pwmfd_tick #(
      .TICK_W   (TICK_W),
      .PRESC_EN (PRESC_EN),
      .PRE_L1   (PRE_L1),
      .PRE_L2   (PRE_L2),
      .PRE_L3   (PRE_L3)
   ) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .psel        (psel),
      .ph_o        (ph),
      .first_cyc_o (first_cyc),
      .adv_o       (adv)
   );

   pwmfd_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .adv        (adv),
      .per_buf    (per_buf),
      .duty_buf   (duty_buf),
      .fine_buf   (fine_buf),
      .tmr_o      (tmr),
      .per_act_o  (per_act),
      .duty_act_o (duty_act),
      .fine_act_o (fine_act),
      .wrap_o     (wrap)
   );

   pwmfd_outgen #(
      .TMR_W      (TMR_W),
      .FINE_W     (FINE_W),
      .ONESHOT_EN (ONESHOT_EN)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_mode  (run_mode),
      .tmr       (tmr),
      .duty_act  (duty_act),
      .fine_act  (fine_act),
      .ph        (ph),
      .first_cyc (first_cyc),
      .pwm_o     (pwm_o)
   );

endmodule

// File: rtl/pwmfd_chk.sv
module pwmfd_chk #(
   parameter int TMR_W  = 16,
   parameter int TICK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic [TMR_W-1:0]  tmr,
   input logic [TMR_W-1:0]  per_act,
   input logic [TMR_W-1:0]  duty_act,
   input logic [TICK_W-1:0] fine_act,
   input logic [TICK_W-1:0] ph,
   input logic              adv,
   input logic              wrap,
   input logic              run,
   input logic              pwm_o
);

   // R1
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b000) |=> !pwm_o);

   // R2
   timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr <= per_act);

   // R2
   rise_at_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_o) && ($past(mode) == $past(mode, 2))) |-> ($past(tmr) == '0));

   // R4
   fall_at_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_o) && ($past(mode[2:1]) == 2'b11) && ($past(duty_act) != '0))
      |-> (($past(tmr) == $past(duty_act)) && ($past(ph) == $past(fine_act))));

   // R5
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv) |=> $stable(tmr));

   // R6
   staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(per_act) && $stable(duty_act) && $stable(fine_act)));

endmodule

bind pwmfd_top pwmfd_chk #(.TMR_W(TMR_W), .TICK_W(TICK_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode_q),
   .tmr      (tmr),
   .per_act  (per_act),
   .duty_act (duty_act),
   .fine_act (fine_act),
   .ph       (ph),
   .adv      (adv),
   .wrap     (wrap),
   .run      (run),
   .pwm_o    (pwm_o)
);

// File: tb/pwmfd_top_tb.sv
module pwmfd_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_o;

   pwmfd_top u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_o   (pwm_o)
   );

   always #2 clk = ~clk;

   typedef struct {
      int    hi;
      int    len;
      string tag;
   } item_t;

   item_t exp_q[$];
   item_t it;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    mon_en = 1'b0;
   int    skip_n = 0;
   bit    started = 1'b0;
   bit    prev = 1'b0;
   int    m_hi = 0;
   int    m_len = 0;
   int    cur_hi = 0;
   int    cur_len = 0;
   int    wd = 0;
   event  rise_ev;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int ratio(input int psel);
      case (psel)
         0: return 1;
         1: return 8;
         2: return 64;
         default: return 256;
      endcase
   endfunction

   function automatic int ctrl(input int mode, input int psel, input int fine);
      return mode | (psel << 4) | (fine << 8);
   endfunction

   // caller stands at posedge + 1
   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = a[1:0];
      wr_data = d[15:0];
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic push(input int hi, input int len, input string tag, input int n);
      item_t x;
      x.hi = hi; x.len = len; x.tag = tag;
      repeat (n) exp_q.push_back(x);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
      #1;
   endtask

   task automatic count_hi(input int n, output int hs);
      hs = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_o) hs++;
      end
      @(posedge clk);
      #1;
   endtask

   // driver: reprogram right after a rising edge, queue expected periods
   task automatic step(input int per, input int duty, input int fine, input int psel,
                       input int mode, input bit skip, input int n, input string tag);
      @(rise_ev);
      @(posedge clk);
      #1;
      wr(1, per);
      wr(2, duty);
      wr(0, ctrl(mode, psel, fine));
      if (skip) skip_n = 1;
      else push(cur_hi, cur_len, {tag, " prior period kept R6"}, 1);
      cur_len = 4 * ratio(psel) * (per + 1);
      cur_hi  = 4 * ratio(psel) * duty + fine;
      push(cur_hi, cur_len, tag, n);
      drain();
   endtask

   // monitor: measures each period from rising edge to rising edge
   always @(negedge clk) begin
      if (!mon_en) begin
         started = 1'b0;
         prev    = pwm_o;
      end else begin
         if (pwm_o && !prev) begin
            if (started) begin
               if (skip_n > 0) skip_n--;
               else if (exp_q.size() > 0) begin
                  it = exp_q.pop_front();
                  check(m_hi == it.hi, {it.tag, " high time"}, m_hi, it.hi);
                  check(m_len == it.len, {it.tag, " period"}, m_len, it.len);
               end
            end
            started = 1'b1;
            m_hi    = 0;
            m_len   = 0;
            -> rise_ev;
         end
         if (started) begin
            m_len++;
            if (pwm_o) m_hi++;
         end
         prev = pwm_o;
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd == 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected run end", wd);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int hs;
      hs = 0;
      repeat (4) begin
         @(negedge clk);
         if (pwm_o) hs++;
      end
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      count_hi(10, hs);
      // R1: low in and out of reset
      check(hs == 0, "R1 reset state", hs, 0);

      // R2 R3 R9: first enable, period 9, duty 4, fine 0, ratio 1
      mon_en = 1'b1;
      wr(1, 9);
      wr(2, 4);
      wr(0, ctrl(6, 0, 0));
      cur_hi  = 16;
      cur_len = 40;
      push(cur_hi, cur_len, "R2 R3 R9 enable", 3);
      drain();

      // R4: code 2 gives half an instruction cycle
      step(9, 4, 2, 0, 6, 1'b0, 2, "R4 fine code 2");
      // R3 R6: new duty and fine together
      step(9, 7, 3, 0, 6, 1'b0, 2, "R3 duty 7 fine 3");
      // R2 R6: longer period
      step(15, 7, 3, 0, 6, 1'b0, 2, "R2 period 15");
      // R3: duty equal to period, one tick low
      step(15, 15, 3, 0, 6, 1'b0, 2, "R3 duty equals period");
      // R5: prescale 8, fine still in clock ticks
      step(5, 2, 1, 1, 7, 1'b1, 2, "R5 prescale 8");
      // R5: prescale 64
      step(1, 1, 2, 2, 7, 1'b1, 2, "R5 prescale 64");

      // R7: duty zero stays low, fine ignored
      mon_en = 1'b0;
      wr(1, 5);
      wr(2, 0);
      wr(0, ctrl(7, 1, 3));
      repeat (800) @(posedge clk);
      #1;
      count_hi(192, hs);
      check(hs == 0, "R7 duty zero", hs, 0);

      // R7: duty above period stays high
      wr(2, 9);
      repeat (400) @(posedge clk);
      #1;
      count_hi(192, hs);
      check(hs == 192, "R7 duty above period", hs, 192);

      // R1: mode off forces low
      wr(0, ctrl(0, 0, 0));
      @(posedge clk);
      #1;
      count_hi(20, hs);
      check(hs == 0, "R1 mode off", hs, 0);

      // R8: single compare, fine ignored
      wr(1, 100);
      wr(2, 5);
      wr(0, ctrl(1, 0, 3));
      count_hi(500, hs);
      check(hs == 20, "R8 single compare high time", hs, 20);
      check(pwm_o == 1'b0, "R8 stays low after match", int'(pwm_o), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule